// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Port

This block is a 32-pin general-purpose I/O port. Every pin is configured on its own as a driven output, a plain input, or an input that can flag an interrupt. Inputs cross into the clock domain through a two-flop synchronizer. After that, each interrupt-capable pin is watched for its own trigger condition: a rising edge, a falling edge, a high level or a low level.

A trigger event sets a sticky pending bit for that pin. Software clears a pending bit by writing 1 to it. All pending bits that are unmasked are ORed onto one shared interrupt line. Software reaches the configuration through a flat bus of eight 32-bit words. Writes take effect on the clock edge that accepts them, and reads are combinational. The port exposes only output-value and output-enable vectors; pads and pin sharing belong to the surrounding logic.

Top module: `gpio_irq_port`

## Requirements
- R1: While rst_ni is low and right after it rises, every configuration word, every pending bit, gpio_o, gpio_oe_o and irq_o are zero.
- R2: A bus write (req_i=1, we_i=1) updates the configuration word it addresses on that clock edge, and reads return the stored value. The word indices are: 0 = direction (1 = output), 1 = output value, 3 = interrupt enable, 4 = trigger kind (0 = edge, 1 = level), 5 = trigger polarity (1 = rising/high, 0 = falling/low), 6 = mask. Cycles without a write leave every word unchanged.
- R3: gpio_oe_o always equals the direction word, and gpio_o always equals the output-value word.
- R4: Word 2 reads the synchronized pin inputs, which follow gpio_i two clock edges late. Writes to word 2 change nothing.
- R5: A pin with direction 0, interrupt enable 1, kind 0 and polarity 1 sets its pending bit (word 7) on the third clock edge after gpio_i goes from 0 to 1. A 1-to-0 change does not set it.
- R6: With kind 0 and polarity 0, the pending bit is set by a 1-to-0 transition only.
- R7: With kind 1, the pending bit is set on every edge at which the synchronized input equals the polarity bit. A write-1 clear made while that level persists therefore leaves the bit set.
- R8: Writing word 7 clears every pending bit written as 1 and leaves bits written as 0 unchanged. If a trigger event and a clear hit the same bit in the same cycle, the event wins.
- R9: A pin sets no pending bit when its direction is 1 or its interrupt enable is 0. A pin configured as a plain input still shows its value in word 2.
- R10: irq_o is 1 exactly when some pending bit has its mask bit set. It follows the pending and mask words in the same cycle.
- R11: Each pin's trigger behaviour depends only on its own configuration bits and its own input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable (valid with req_i) |
| addr_i | input | 3 | Word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| gpio_i | input | 32 | Asynchronous pin inputs |
| gpio_o | output | 32 | Output values |
| gpio_oe_o | output | 32 | Output enables |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The hardest case to reach is a trigger event and a write-1 clear landing on the same pin in the same cycle. Because the pin path has a three-edge latency, this has to be aimed at. The bench schedules a clear exactly three edges after toggling a rising-edge pin, and repeats the clear against a held level. It also compares the whole port against a behavioural model on every cycle during a long random phase. In that phase the inputs, directions, trigger settings and clears change together, so these collisions also occur across many pins at once.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    IDX_DIR  = 3'd0,
    IDX_OUT  = 3'd1,
    IDX_IN   = 3'd2,
    IDX_IEN  = 3'd3,
    IDX_KIND = 3'd4,
    IDX_POL  = 3'd5,
    IDX_MASK = 3'd6,
    IDX_PEND = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic kind; // 0 edge, 1 level
    logic pol;  // 1 rising/high, 0 falling/low
  } trig_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      sync_in_i,
  input  logic [W-1:0]      pend_i,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      ien_o,
  output logic [W-1:0]      kind_o,
  output logic [W-1:0]      pol_o,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      clr_o
);
  logic wr;
  logic [W-1:0] dir_q, out_q, ien_q, kind_q, pol_q, mask_q;

  assign wr = req_i && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      ien_q  <= '0;
      kind_q <= '0;
      pol_q  <= '0;
      mask_q <= '0;
    end else if (wr) begin
      unique case (reg_idx_e'(addr_i))
        IDX_DIR:  dir_q  <= wdata_i;
        IDX_OUT:  out_q  <= wdata_i;
        IDX_IEN:  ien_q  <= wdata_i;
        IDX_KIND: kind_q <= wdata_i;
        IDX_POL:  pol_q  <= wdata_i;
        IDX_MASK: mask_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_o = (wr && reg_idx_e'(addr_i) == IDX_PEND) ? wdata_i : '0;

  always_comb begin
    unique case (reg_idx_e'(addr_i))
      IDX_DIR:  rdata_o = dir_q;
      IDX_OUT:  rdata_o = out_q;
      IDX_IN:   rdata_o = sync_in_i;
      IDX_IEN:  rdata_o = ien_q;
      IDX_KIND: rdata_o = kind_q;
      IDX_POL:  rdata_o = pol_q;
      IDX_MASK: rdata_o = mask_q;
      default:  rdata_o = pend_i;
    endcase
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign ien_o  = ien_q;
  assign kind_o = kind_q;
  assign pol_o  = pol_q;
  assign mask_o = mask_q;

  a_r2_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> ($stable(dir_q) && $stable(out_q) && $stable(ien_q) &&
             $stable(kind_q) && $stable(pol_q) && $stable(mask_q)));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] ien_i,
  input  logic [W-1:0] kind_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);
  logic [W-1:0] prev_q, pend_q, set_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cur_i;
  end

  for (genvar p = 0; p < W; p++) begin : g_pin
    trig_cfg_t cfg;
    logic      hit;
    assign cfg = '{kind: kind_i[p], pol: pol_i[p]};
    always_comb begin
      if (cfg.kind) hit = (cur_i[p] == cfg.pol);
      else if (cfg.pol) hit = cur_i[p] & ~prev_q[p];
      else hit = ~cur_i[p] & prev_q[p];
    end
    assign set_vec[p] = hit & ~dir_i[p] & ien_i[p];
  end

  // event has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= set_vec | (pend_q & ~clr_i);
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & mask_i);

  a_r5_event_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  a_r8_drop_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_q) & ~pend_q & ~$past(clr_i)) == '0));

  a_r9_inactive_never_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ($past(dir_i) | ~$past(ien_i))) == '0));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  input  logic [NPINS-1:0]  gpio_i,
  output logic [NPINS-1:0]  gpio_o,
  output logic [NPINS-1:0]  gpio_oe_o,
  output logic              irq_o
);
  logic [NPINS-1:0] sync_in, pend, dir, outv, ien, kind, pol, mask, clr;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (sync_in)
  );

  gpio_regs #(.W(NPINS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .sync_in_i(sync_in),
    .pend_i   (pend),
    .dir_o    (dir),
    .out_o    (outv),
    .ien_o    (ien),
    .kind_o   (kind),
    .pol_o    (pol),
    .mask_o   (mask),
    .clr_o    (clr)
  );

  gpio_irq_unit #(.W(NPINS)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cur_i (sync_in),
    .dir_i (dir),
    .ien_i (ien),
    .kind_i(kind),
    .pol_i (pol),
    .mask_i(mask),
    .clr_i (clr),
    .pend_o(pend),
    .irq_o (irq_o)
  );

  assign gpio_o    = outv;
  assign gpio_oe_o = dir;

  a_r10_irq_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend != '0));
endmodule

// File: tb/gpio_irq_port_test.sv
`timescale 1ns/1ps
module gpio_irq_port_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [2:0]  addr_i = 3'd0;
  logic [31:0] wdata_i = '0, gpio_i = '0;
  logic [31:0] rdata_o, gpio_o, gpio_oe_o;
  logic        irq_o;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;
  string ptag = "R5";

  // model state
  logic [31:0] m_dir, m_out, m_ien, m_kind, m_pol, m_mask, m_pend, m_s1, m_s2, m_prev;

  gpio_irq_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .gpio_i(gpio_i), .gpio_o(gpio_o),
    .gpio_oe_o(gpio_oe_o), .irq_o(irq_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_dir;
      3'd1: return m_out;
      3'd2: return m_s2;
      3'd3: return m_ien;
      3'd4: return m_kind;
      3'd5: return m_pol;
      3'd6: return m_mask;
      default: return m_pend;
    endcase
  endfunction

  // reference model and per-cycle comparison
  always begin
    @(posedge clk);
    if (!rst_ni) begin
      {m_dir, m_out, m_ien, m_kind, m_pol, m_mask, m_pend, m_s1, m_s2, m_prev} = '0;
    end else begin
      logic [31:0] clr, nxt;
      clr = (req_i && we_i && addr_i == 3'd7) ? wdata_i : 32'h0;
      for (int p = 0; p < 32; p++) begin
        bit ev;
        if (m_kind[p]) ev = (m_s2[p] == m_pol[p]);
        else if (m_pol[p]) ev = m_s2[p] && !m_prev[p];
        else ev = !m_s2[p] && m_prev[p];
        ev = ev && !m_dir[p] && m_ien[p];
        nxt[p] = ev || (m_pend[p] && !clr[p]);
      end
      m_pend = nxt;
      m_prev = m_s2;
      m_s2 = m_s1;
      m_s1 = gpio_i;
      if (req_i && we_i) begin
        case (addr_i)
          3'd0: m_dir = wdata_i;
          3'd1: m_out = wdata_i;
          3'd3: m_ien = wdata_i;
          3'd4: m_kind = wdata_i;
          3'd5: m_pol = wdata_i;
          3'd6: m_mask = wdata_i;
          default: ;
        endcase
      end
    end
    #1;
    chk("R3 gpio_o", gpio_o, m_out);
    chk("R3 gpio_oe_o", gpio_oe_o, m_dir);
    chk("R10 irq_o", {31'h0, irq_o}, {31'h0, |(m_pend & m_mask)});
    if (addr_i == 3'd7)      chk({ptag, " pending read"}, rdata_o, m_pend);
    else if (addr_i == 3'd2) chk("R4 input read", rdata_o, m_s2);
    else                     chk("R2 config read", rdata_o, m_read(addr_i));
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd_expect(input string tag, input logic [2:0] a, input logic [31:0] e);
    @(negedge clk);
    addr_i = a;
    #0.5;
    chk(tag, rdata_o, e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  always begin
    @(posedge clk);
    cycles++;
    if (cycles > 100000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1 reset values at the ports
    chk("R1 gpio_o", gpio_o, 0);
    chk("R1 gpio_oe_o", gpio_oe_o, 0);
    chk("R1 irq_o", {31'h0, irq_o}, 0);
    rst_ni = 1;
    rd_expect("R1 pending after reset", 3'd7, 0);
    rd_expect("R1 mask after reset", 3'd6, 0);

    // R2 / R3 write and read back
    wr(3'd0, 32'hF000_000F);
    wr(3'd1, 32'hA5A5_5A5A);
    rd_expect("R2 direction", 3'd0, 32'hF000_000F);
    rd_expect("R3 outputs", 3'd1, gpio_o);
    // R4 writes to input word ignored
    gpio_i = 32'h1234_5678;
    wr(3'd2, 32'hFFFF_FFFF);
    idle(2);
    rd_expect("R4 input word", 3'd2, 32'h1234_5678);
    gpio_i = 0;
    wr(3'd0, 0);
    idle(3);

    // R5 rising edge on pin 4, pin 5 gets plain input
    ptag = "R5";
    wr(3'd3, 32'h0000_0010);
    wr(3'd5, 32'h0000_0010);
    wr(3'd6, 32'hFFFF_FFFF);
    @(negedge clk); addr_i = 3'd7; gpio_i = 32'h30;
    @(negedge clk); #0.5 chk("R5 not yet", rdata_o, 0);
    @(negedge clk); #0.5 chk("R5 not yet", rdata_o, 0);
    @(negedge clk); #0.5 chk("R5 set on third edge", rdata_o, 32'h10);
    chk("R10 irq high", {31'h0, irq_o}, 1);
    wr(3'd7, 32'h10);
    gpio_i = 0;
    idle(4);
    rd_expect("R5 falling ignored", 3'd7, 0);
    rd_expect("R9 plain input visible", 3'd2, 0);

    // R8 collision: clear on same edge as event
    ptag = "R8";
    @(negedge clk); gpio_i = 32'h10;
    @(negedge clk);
    @(negedge clk); req_i = 1; we_i = 1; addr_i = 3'd7; wdata_i = 32'h10;
    @(negedge clk); req_i = 0; we_i = 0;
    #0.5 chk("R8 event beats clear", rdata_o, 32'h10);
    wr(3'd7, 32'h0);
    rd_expect("R8 zero write keeps", 3'd7, 32'h10);
    wr(3'd7, 32'h10);
    rd_expect("R8 clear", 3'd7, 0);

    // R6 falling edge
    ptag = "R6";
    wr(3'd5, 32'h0);
    gpio_i = 0;
    idle(4);
    rd_expect("R6 falling sets", 3'd7, 32'h10);
    wr(3'd7, 32'hFFFF_FFFF);

    // R7 level high on pin 9, low on pin 8
    ptag = "R7";
    wr(3'd3, 32'h0000_0300);
    wr(3'd4, 32'h0000_0300);
    wr(3'd5, 32'h0000_0200);
    wr(3'd7, 32'hFFFF_FFFF);
    rd_expect("R7 low level holds pin 8", 3'd7, 32'h100);
    gpio_i = 32'h300;
    idle(4);
    wr(3'd7, 32'h300);
    rd_expect("R7 high level survives clear", 3'd7, 32'h200);
    // R9 output direction blocks
    ptag = "R9";
    wr(3'd0, 32'h200);
    wr(3'd7, 32'h300);
    rd_expect("R9 output pin no pending", 3'd7, 0);
    chk("R10 irq low", {31'h0, irq_o}, 0);
    wr(3'd0, 0);
    wr(3'd6, 32'h0);
    idle(2);
    chk("R10 masked", {31'h0, irq_o}, 0);

    // R11 random mixed configuration
    ptag = "R11";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      gpio_i = gpio_i ^ ($urandom() & $urandom());
      req_i = ($urandom_range(0, 3) == 0);
      we_i = $urandom_range(0, 1);
      addr_i = $urandom_range(0, 7);
      wdata_i = $urandom();
    end
    @(negedge clk); req_i = 0; we_i = 0;
    idle(5);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule